// File: doc/BRIEF.md
# Triggered Compare-and-Clear Unit

This unit sits beside an externally owned 16-bit event counter. Whenever a selected trigger occurs, it compares the counter value with a 16-bit threshold word and registers the result. It raises a one-cycle match pulse if the comparison held, and it always issues a one-cycle clear pulse so that the counter can restart. The counter itself and the register access are outside this unit; all control fields arrive as plain input pins.

A trigger comes from one of two sources. The first is a slow-clock tick, divided by 1, 2, 4 or 8. The second is a rising edge on one of six external channels, after an optional inversion. When gating is enabled, the selected channel can also hold back slow-clock ticks. There are three comparison modes: at-most, at-least, and a window mode. The window mode takes both of its bounds from the two halves of the threshold word.

Top module: `cmpclr_unit`

## Requirements
- R1: While rstN is low, matchPulse, matchLevel and clearPulse are all 0.
- R2: With trigMode 0 (off) or 3 (reserved), neither slow ticks nor channel edges produce any clearPulse.
- R3: With trigMode 1, a trigger fires on every 2^prescSel-th accepted slowTick (prescSel 0..3 gives 1, 2, 4 or 8), counted from the last restart.
- R4: Any change of trigMode or prescSel restarts the tick division. The first trigger after the change comes on the full divisor-th tick. A tick in the same cycle as the change is not counted.
- R5: With trigMode 2, a trigger fires on a 0-to-1 transition of the channel picked by chanSel (codes 0..5). Edges on other channels are ignored, and chanSel codes 6 and 7 never trigger.
- R6: When chanInvert is 1, the selected channel is inverted before edge detection, so a 1-to-0 transition of the raw input triggers.
- R7: With gateEn at 1 in trigMode 1, a slowTick is accepted only while the selected channel (after inversion) is at 1. Otherwise the tick is ignored.
- R8: cmpMode 0 matches when cntVal <= topWord.
- R9: cmpMode 1 matches when cntVal >= topWord.
- R10: cmpMode 2 matches when cntVal >= topWord[7:0] and cntVal <= topWord[15:8]. Both bytes are zero-extended.
- R11: cmpMode 3 never matches.
- R12: Take a trigger in the cycle sampled by clock edge k. After edge k, clearPulse is 1 for one cycle, matchPulse equals the comparison result for one cycle, and matchLevel holds that result until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slowTick | input | 1 | One-cycle pulse per slow-clock period, synchronous to clk |
| extTrig | input | 6 | External trigger channels, synchronous to clk |
| cntVal | input | 16 | Current counter value |
| topWord | input | 16 | Threshold word (in window mode: high byte is upper bound, low byte is lower bound) |
| trigMode | input | 2 | 0 off, 1 divided slow tick, 2 channel edge, 3 off |
| prescSel | input | 2 | Tick divisor code: divide by 2^code |
| cmpMode | input | 2 | 0 at-most, 1 at-least, 2 window, 3 never |
| chanSel | input | 3 | External channel index 0..5; 6 and 7 select none |
| chanInvert | input | 1 | Invert the selected channel |
| gateEn | input | 1 | Let the selected channel gate slow ticks |
| matchPulse | output | 1 | One-cycle pulse on a trigger that matched |
| matchLevel | output | 1 | Result of the most recent triggered comparison |
| clearPulse | output | 1 | One-cycle counter-clear pulse per trigger |

## Verification
Some properties are checked by assertions on every cycle:
- A match pulse never appears without a clear pulse.
- The match level changes only after a trigger.
- Disabled trigger modes, a channel code with no channel, and a configuration-change cycle never fire.
- The tick phase stays below the divisor.
- Trigger cycles under the at-most, at-least and reserved compare codes give the expected match pulse.

Other behaviour can only be shown by the bench scenarios, because it depends on a sequence of stimuli. This covers the exact spacing of triggers for each divisor code, the restart of division after a configuration change, edge and polarity behaviour, and gating. It also covers the boundary sweeps of every compare mode at each bound and one step either side.

// File: rtl/cmpclr_pkg.sv
package cmpclr_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_TICK = 2'd1,
    TRIG_EDGE = 2'd2,
    TRIG_RSVD = 2'd3
  } trigSrc_e;

  typedef enum logic [1:0] {
    CMP_AT_MOST  = 2'd0,
    CMP_AT_LEAST = 2'd1,
    CMP_WINDOW   = 2'd2,
    CMP_NEVER    = 2'd3
  } cmpSel_e;

  // strobes handed from trigger control to the compare datapath
  typedef struct packed {
    logic sample;  // capture the comparison result
    logic clear;   // request a counter clear
  } ctrlStrobe_t;

endpackage

// File: rtl/cmpclr_ctrl.sv
module cmpclr_ctrl
  import cmpclr_pkg::*;
#(
  parameter int NUM_CH  = 6,
  parameter int SEL_W   = 3,
  parameter int PRESC_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               slowTick,
  input  logic [NUM_CH-1:0]  extTrig,
  input  logic [1:0]         trigMode,
  input  logic [PRESC_W-1:0] prescSel,
  input  logic [SEL_W-1:0]   chanSel,
  input  logic               chanInvert,
  input  logic               gateEn,
  output ctrlStrobe_t        strobe
);

  // widest divisor is 2^(2^PRESC_W - 1); the phase counter spans it
  localparam int MAX_LOG = (1 << PRESC_W) - 1;
  localparam int PH_W    = (MAX_LOG > 0) ? MAX_LOG : 1;
  localparam int CFG_W   = 2 + PRESC_W;

  trigSrc_e          srcSel;
  logic [NUM_CH-1:0] chanHit;
  logic              chanRaw;
  logic              chanLvl;
  logic              prevLvl;
  logic              edgeSeen;
  logic              gateOpen;
  logic              tickAccept;
  logic [PH_W-1:0]   phase;
  logic [PH_W-1:0]   lastPhase;
  logic [CFG_W-1:0]  cfgNow;
  logic [CFG_W-1:0]  cfgPrev;
  logic              cfgChanged;
  logic              fireTick;
  logic              fireEdge;
  logic              fire;

  assign srcSel = trigSrc_e'(trigMode);

  // one-hot channel pick; codes at or above NUM_CH pick nothing
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign chanHit[g] = (chanSel == SEL_W'(g)) & extTrig[g];
  end
  assign chanRaw = |chanHit;
  assign chanLvl = chanRaw ^ chanInvert;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= chanLvl;
  end
  assign edgeSeen = chanLvl & ~prevLvl;

  // configuration change detection restarts the divider
  assign cfgNow     = {trigMode, prescSel};
  assign cfgChanged = (cfgNow != cfgPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgPrev <= '0;
    else       cfgPrev <= cfgNow;
  end

  assign lastPhase  = PH_W'((32'd1 << prescSel) - 32'd1);
  assign gateOpen   = !gateEn || chanLvl;
  assign tickAccept = (srcSel == TRIG_TICK) && slowTick && gateOpen && !cfgChanged;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (cfgChanged) begin
      phase <= '0;
    end else if (tickAccept) begin
      phase <= (phase == lastPhase) ? '0 : phase + 1'b1;
    end
  end

  assign fireTick = tickAccept && (phase == lastPhase);
  assign fireEdge = (srcSel == TRIG_EDGE) && edgeSeen;
  assign fire     = fireTick | fireEdge;

  assign strobe.sample = fire;
  assign strobe.clear  = fire;

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigMode == 2'd0 || trigMode == 2'd3) |-> !strobe.clear);

  // R3
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgChanged |-> (phase <= lastPhase));

  // R4
  change_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgChanged && trigMode == 2'd1) |-> !strobe.sample);

  // R5
  no_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigMode == 2'd2 && chanSel >= SEL_W'(NUM_CH)) |-> !strobe.sample);

endmodule

// File: rtl/cmpclr_dp.sv
module cmpclr_dp
  import cmpclr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [1:0]       cmpMode,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] topWord,
  output logic             matchPulse,
  output logic             matchLevel,
  output logic             clearPulse
);

  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] loBound;
  logic [CNT_W-1:0] hiBound;
  logic             hitNow;

  assign loBound = CNT_W'(topWord[HALF-1:0]);
  assign hiBound = CNT_W'(topWord[CNT_W-1:HALF]);

  always_comb begin
    unique case (cmpSel_e'(cmpMode))
      CMP_AT_MOST:  hitNow = (cntVal <= topWord);
      CMP_AT_LEAST: hitNow = (cntVal >= topWord);
      CMP_WINDOW:   hitNow = (cntVal >= loBound) && (cntVal <= hiBound);
      default:      hitNow = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchPulse <= 1'b0;
      matchLevel <= 1'b0;
      clearPulse <= 1'b0;
    end else begin
      matchPulse <= strobe.sample & hitNow;
      clearPulse <= strobe.clear;
      if (strobe.sample) matchLevel <= hitNow;
    end
  end

  // R12
  pulse_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> (clearPulse && matchLevel));

  // R12
  clear_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearPulse |-> $past(strobe.clear));

  // R12
  level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sample |=> $stable(matchLevel));

  // R8
  le_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sample && cmpMode == 2'd0 && cntVal <= topWord) |=> matchPulse);

  // R9
  ge_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sample && cmpMode == 2'd1 && cntVal >= topWord) |=> matchPulse);

  // R11
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sample && cmpMode == 2'd3) |=> !matchPulse);

endmodule

// File: rtl/cmpclr_unit.sv
module cmpclr_unit
  import cmpclr_pkg::*;
#(
  parameter int NUM_CH  = 6,
  parameter int SEL_W   = 3,
  parameter int PRESC_W = 2,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               slowTick,
  input  logic [NUM_CH-1:0]  extTrig,
  input  logic [CNT_W-1:0]   cntVal,
  input  logic [CNT_W-1:0]   topWord,
  input  logic [1:0]         trigMode,
  input  logic [PRESC_W-1:0] prescSel,
  input  logic [1:0]         cmpMode,
  input  logic [SEL_W-1:0]   chanSel,
  input  logic               chanInvert,
  input  logic               gateEn,
  output logic               matchPulse,
  output logic               matchLevel,
  output logic               clearPulse
);

  ctrlStrobe_t strobe;

  cmpclr_ctrl #(
    .NUM_CH (NUM_CH),
    .SEL_W  (SEL_W),
    .PRESC_W(PRESC_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .slowTick  (slowTick),
    .extTrig   (extTrig),
    .trigMode  (trigMode),
    .prescSel  (prescSel),
    .chanSel   (chanSel),
    .chanInvert(chanInvert),
    .gateEn    (gateEn),
    .strobe    (strobe)
  );

  cmpclr_dp #(
    .CNT_W(CNT_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmpMode   (cmpMode),
    .cntVal    (cntVal),
    .topWord   (topWord),
    .matchPulse(matchPulse),
    .matchLevel(matchLevel),
    .clearPulse(clearPulse)
  );

endmodule

// File: tb/cmpclr_unit_tb_top.sv
`timescale 1ns/1ps
module cmpclr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        slowTick;
  logic [5:0]  extTrig;
  logic [15:0] cntVal;
  logic [15:0] topWord;
  logic [1:0]  trigMode;
  logic [1:0]  prescSel;
  logic [1:0]  cmpMode;
  logic [2:0]  chanSel;
  logic        chanInvert;
  logic        gateEn;
  logic        matchPulse;
  logic        matchLevel;
  logic        clearPulse;

  always #2 clk = ~clk;

  cmpclr_unit dut_i (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .extTrig(extTrig),
    .cntVal(cntVal), .topWord(topWord), .trigMode(trigMode),
    .prescSel(prescSel), .cmpMode(cmpMode), .chanSel(chanSel),
    .chanInvert(chanInvert), .gateEn(gateEn), .matchPulse(matchPulse),
    .matchLevel(matchLevel), .clearPulse(clearPulse)
  );

  typedef struct {
    int    cyc;
    logic  mp;
    logic  ml;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t it;
  int    vectors = 0;
  int    misses  = 0;
  int    cyc     = 0;
  string curTag  = "R1";
  logic  lastLvl = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops an expected item for every clear pulse
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      while (expQ.size() > 0 && expQ[0].cyc < cyc) begin
        it = expQ.pop_front();
        vectors++; misses++;
        $display("FAIL %s: no clear pulse at cycle %0d (actual 0, expected 1)", it.tag, it.cyc);
      end
      if (clearPulse === 1'b1) begin
        vectors++;
        if (expQ.size() == 0) begin
          misses++;
          $display("FAIL %s: clear pulse at cycle %0d (actual 1, expected 0)", curTag, cyc);
        end else begin
          it = expQ.pop_front();
          if (it.cyc != cyc || matchPulse !== it.mp || matchLevel !== it.ml) begin
            misses++;
            $display("FAIL %s: cycle/match/level actual %0d/%b/%b expected %0d/%b/%b",
                     it.tag, cyc, matchPulse, matchLevel, it.cyc, it.mp, it.ml);
          end
        end
      end else if (matchPulse === 1'b1) begin
        vectors++; misses++;
        $display("FAIL %s: match pulse without clear (actual 1, expected 0)", curTag);
      end
    end
  end

  function automatic logic expHit();
    case (cmpMode)
      2'd0:    return cntVal <= topWord;                               // R8
      2'd1:    return cntVal >= topWord;                               // R9
      2'd2:    return (cntVal >= {8'h00, topWord[7:0]}) &&
                      (cntVal <= {8'h00, topWord[15:8]});              // R10
      default: return 1'b0;                                            // R11
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pushExp(input string tag);
    logic h;
    h = expHit();
    expQ.push_back('{cyc + 1, h, h, tag});
    lastLvl = h;
  endtask

  task automatic tick(input logic fires, input string tag);
    curTag = tag;
    slowTick = 1'b1;
    if (fires) pushExp(tag);
    step();
    slowTick = 1'b0;
    step();
  endtask

  task automatic chan(input int idx, input logic val, input logic fires, input string tag);
    curTag = tag;
    extTrig[idx] = val;
    if (fires) pushExp(tag);
    step();
    step();
  endtask

  task automatic setCfg(input logic [1:0] m, input logic [1:0] p);
    trigMode = m;
    prescSel = p;
    step();
    step();
  endtask

  task automatic drain(input string tag);
    step(); step(); step();
    vectors++;
    if (expQ.size() != 0 || clearPulse !== 1'b0 || matchLevel !== lastLvl) begin
      misses++;
      $display("FAIL %s: idle pending/clear/level actual %0d/%b/%b expected 0/0/%b",
               tag, expQ.size(), clearPulse, matchLevel, lastLvl);
    end
  endtask

  task automatic cmpSweep(input logic [1:0] m, input logic [15:0] top,
                          input logic [15:0] val, input string tag);
    cmpMode = m;
    topWord = top;
    cntVal  = val;
    tick(1'b1, tag);
  endtask

  task automatic runAll();
    rstN = 1'b0; slowTick = 1'b0; extTrig = '0; cntVal = '0; topWord = '0;
    trigMode = '0; prescSel = '0; cmpMode = '0; chanSel = 3'd7;
    chanInvert = 1'b0; gateEn = 1'b0;
    step(); step();
    // R1
    vectors++;
    if (matchPulse !== 1'b0 || matchLevel !== 1'b0 || clearPulse !== 1'b0) begin
      misses++;
      $display("FAIL R1: reset outputs actual %b%b%b expected 000", matchPulse, matchLevel, clearPulse);
    end
    rstN = 1'b1;
    step();

    // R2: off and reserved trigger modes stay quiet
    cntVal = 16'd1; topWord = 16'd2; chanSel = 3'd0;
    tick(1'b0, "R2"); tick(1'b0, "R2");
    chan(0, 1'b1, 1'b0, "R2"); chan(0, 1'b0, 1'b0, "R2");
    setCfg(2'd3, 2'd0);
    tick(1'b0, "R2"); chan(0, 1'b1, 1'b0, "R2"); chan(0, 1'b0, 1'b0, "R2");
    drain("R2");

    // R3: spacing for every divisor code
    chanSel = 3'd7; cmpMode = 2'd0; cntVal = 16'd5; topWord = 16'd10;
    for (int code = 0; code < 4; code++) begin
      int d;
      d = 1 << code;
      setCfg(2'd1, 2'(code));
      for (int k = 0; k < 2 * d; k++) tick((k % d) == d - 1, "R3");
      drain("R3");
    end

    // R4: divisor change mid-count restarts
    setCfg(2'd1, 2'd3);
    for (int k = 0; k < 3; k++) tick(1'b0, "R4");
    setCfg(2'd1, 2'd2);
    for (int k = 0; k < 4; k++) tick(k == 3, "R4");
    for (int k = 0; k < 2; k++) tick(1'b0, "R4");
    setCfg(2'd0, 2'd2);
    setCfg(2'd1, 2'd2);
    for (int k = 0; k < 4; k++) tick(k == 3, "R4");
    drain("R4");

    // R12: level follows each trigger and holds between
    setCfg(2'd1, 2'd0);
    cntVal = 16'd5; topWord = 16'd10; tick(1'b1, "R12"); drain("R12");
    cntVal = 16'd20; tick(1'b1, "R12"); drain("R12");

    // R8 / R9 boundaries
    for (int s = -1; s <= 1; s++) cmpSweep(2'd0, 16'h1234, 16'(16'h1234 + s), "R8");
    drain("R8");
    for (int s = -1; s <= 1; s++) cmpSweep(2'd1, 16'h1234, 16'(16'h1234 + s), "R9");
    drain("R9");
    // R10: window lower bound 0x20, upper bound 0x40
    for (int s = -1; s <= 1; s++) cmpSweep(2'd2, 16'h4020, 16'(16'h0020 + s), "R10");
    for (int s = -1; s <= 1; s++) cmpSweep(2'd2, 16'h4020, 16'(16'h0040 + s), "R10");
    cmpSweep(2'd2, 16'h4020, 16'h0130, "R10");
    drain("R10");
    // R11
    cmpSweep(2'd3, 16'h0000, 16'h0000, "R11");
    cmpSweep(2'd3, 16'hFFFF, 16'h8000, "R11");
    drain("R11");

    // R5: edges on the selected channel only
    cmpMode = 2'd0; cntVal = 16'd3; topWord = 16'd9;
    setCfg(2'd0, 2'd0);
    extTrig = '0; chanSel = 3'd3; step(); step();
    setCfg(2'd2, 2'd0);
    chan(3, 1'b1, 1'b1, "R5"); chan(3, 1'b0, 1'b0, "R5");
    chan(4, 1'b1, 1'b0, "R5"); chan(4, 1'b0, 1'b0, "R5");
    tick(1'b0, "R5");
    chanSel = 3'd6; step(); step();
    for (int c = 0; c < 6; c++) begin
      chan(c, 1'b1, 1'b0, "R5"); chan(c, 1'b0, 1'b0, "R5");
    end
    chanSel = 3'd7; step(); step();
    chan(5, 1'b1, 1'b0, "R5"); chan(5, 1'b0, 1'b0, "R5");
    drain("R5");

    // R6: inverted polarity fires on the falling raw edge
    setCfg(2'd0, 2'd0);
    chanSel = 3'd2; chanInvert = 1'b1; step(); step();
    setCfg(2'd2, 2'd0);
    chan(2, 1'b1, 1'b0, "R6"); chan(2, 1'b0, 1'b1, "R6");
    drain("R6");
    setCfg(2'd0, 2'd0);
    chanInvert = 1'b0; step(); step();

    // R7: gated ticks
    gateEn = 1'b1; chanSel = 3'd1; extTrig = '0; step(); step();
    setCfg(2'd1, 2'd0);
    tick(1'b0, "R7");
    extTrig[1] = 1'b1; step();
    tick(1'b1, "R7");
    chanInvert = 1'b1; step(); step();
    tick(1'b0, "R7");
    drain("R7");
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        vectors++; misses++;
        $display("FAIL watchdog: run hung (actual timeout, expected completion)");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule